// File: doc/BRIEF.md
# Alias-Mapped Control Register with Command Strobes

This block holds one 32-bit control word behind a simple address/data write port. Three write addresses lead to that same word, and each changes it in its own way. One clears the bits that are set in the written data. One sets the bits that are set in the written data. One replaces the whole word. Because each change is made inside the block, software can alter a few bits without a read-modify-write race against other agents.

A fourth address stores nothing. Each low bit of the data written there fires a single-cycle strobe toward the surrounding logic: a counter reset, a counter latch, or a forced trigger.

The latch strobe also loads a bank of shadow registers from live counter inputs. Reads of the shadow bank therefore return values that were all captured in the same clock cycle, so they are consistent with one another. A combinational read port returns the control word, the shadow values, or zero.

Top module: `ctrl_alias_reg`

## Requirements
- R1: While `rstN` is low, and immediately after it rises, `ctrlWord` is zero, all three strobes are low and every shadow value reads as zero.
- R2: A write to address 0x3D makes `ctrlWord` equal to its previous value AND the inverse of `wrData`, visible in the cycle after the write edge.
- R3: A write to address 0x3E makes `ctrlWord` equal to its previous value OR `wrData`, visible in the cycle after the write edge.
- R4: A write to address 0x3F replaces `ctrlWord` with `wrData`, visible in the cycle after the write edge.
- R5: `ctrlWord` keeps its value in any cycle without a write to 0x3D, 0x3E or 0x3F. This includes writes to the command address, writes to any other address, and cycles with `wrEn` low.
- R6: A write to command address 0x2B drives the strobes for exactly the one cycle after the write edge. Data bit 0 drives `cntClearStb`, bit 1 drives `cntSnapStb` and bit 2 drives `trigFireStb`. All other data bits are ignored.
- R7: A read of 0x2B returns zero. A read of 0x3D, 0x3E or 0x3F returns the current `ctrlWord`.
- R8: At the clock edge that ends a cycle in which `cntSnapStb` is high, shadow slot i loads live value i (bits [32*i+31:32*i] of `liveCounts`). At all other edges the slots hold their values. A read of address 0x100+i returns slot i.
- R9: A read of any other address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 12 | Write address |
| wrData | input | 32 | Write data |
| rdAddr | input | 12 | Read address |
| rdData | output | 32 | Read data (combinational) |
| liveCounts | input | 128 | Four live 32-bit counter values |
| ctrlWord | output | 32 | Current control word |
| cntClearStb | output | 1 | Counter reset strobe |
| cntSnapStb | output | 1 | Counter latch strobe |
| trigFireStb | output | 1 | Forced trigger strobe |

## Verification
The bench drives long runs of back-to-back alias writes. A design that reads a stale base value for the clear or set mask would lose bits that an earlier write had just changed.

Command writes carry extra high data bits and arrive in consecutive cycles. A strobe that lasts longer than one cycle, or that reacts to bits above bit 2, is caught the cycle after it appears.

The live counter inputs change every cycle. A shadow bank that loads one cycle early or late, or that follows the live inputs between snapshots, shows a different value at its read address. Reads at the command address, the alias addresses and unmapped addresses catch a read mux that leaks the wrong source.

// File: rtl/ctrl_alias_pkg.sv
package ctrl_alias_pkg;
  localparam int DATA_W = 32;

  typedef struct packed {
    logic clrMask;
    logic setMask;
    logic wrFull;
    logic cmd;
    logic [DATA_W-1:0] data;
  } regStrobe_t;
endpackage

// File: rtl/ctrl_alias_decode.sv
module ctrl_alias_decode
  import ctrl_alias_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] CLR_ADDR = 12'h03D,
  parameter logic [ADDR_W-1:0] SET_ADDR = 12'h03E,
  parameter logic [ADDR_W-1:0] FULL_ADDR = 12'h03F,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 12'h02B
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output regStrobe_t        strb
);
  always_comb begin
    strb.clrMask = wrEn && (wrAddr == CLR_ADDR);
    strb.setMask = wrEn && (wrAddr == SET_ADDR);
    strb.wrFull  = wrEn && (wrAddr == FULL_ADDR);
    strb.cmd     = wrEn && (wrAddr == CMD_ADDR);
    strb.data    = wrData;
  end
endmodule

// File: rtl/ctrl_alias_datapath.sv
module ctrl_alias_datapath
  import ctrl_alias_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NUM_SNAP = 4,
  parameter logic [ADDR_W-1:0] CLR_ADDR = 12'h03D,
  parameter logic [ADDR_W-1:0] SET_ADDR = 12'h03E,
  parameter logic [ADDR_W-1:0] FULL_ADDR = 12'h03F,
  parameter logic [ADDR_W-1:0] SNAP_BASE = 12'h100
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  regStrobe_t                 strb,
  input  logic [NUM_SNAP*DATA_W-1:0] liveCounts,
  input  logic [ADDR_W-1:0]          rdAddr,
  output logic [DATA_W-1:0]          rdData,
  output logic [DATA_W-1:0]          ctrlWord,
  output logic                       cntClearStb,
  output logic                       cntSnapStb,
  output logic                       trigFireStb
);
  localparam int SNAP_W = DATA_W;

  logic [SNAP_W-1:0] shadow [NUM_SNAP];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlWord <= '0;
    end else if (strb.wrFull) begin
      ctrlWord <= strb.data;
    end else if (strb.setMask) begin
      ctrlWord <= ctrlWord | strb.data;
    end else if (strb.clrMask) begin
      ctrlWord <= ctrlWord & ~strb.data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntClearStb <= 1'b0;
      cntSnapStb  <= 1'b0;
      trigFireStb <= 1'b0;
    end else begin
      cntClearStb <= strb.cmd && strb.data[0];
      cntSnapStb  <= strb.cmd && strb.data[1];
      trigFireStb <= strb.cmd && strb.data[2];
    end
  end

  for (genvar i = 0; i < NUM_SNAP; i++) begin : gSnap
    always_ff @(posedge clk) begin
      if (!rstN) shadow[i] <= '0;
      else if (cntSnapStb) shadow[i] <= liveCounts[i*SNAP_W +: SNAP_W];
    end
  end

  always_comb begin
    rdData = '0;
    if (rdAddr == CLR_ADDR || rdAddr == SET_ADDR || rdAddr == FULL_ADDR)
      rdData = ctrlWord;
    for (int i = 0; i < NUM_SNAP; i++) begin
      if (rdAddr == SNAP_BASE + ADDR_W'(i)) rdData = shadow[i];
    end
  end

  // Assertions next to the logic they guard
  assert_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(strb.clrMask) && !$past(strb.setMask) && !$past(strb.wrFull)
      |-> ctrlWord == ($past(ctrlWord) & ~$past(strb.data)));

  assert_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(strb.setMask) && !$past(strb.wrFull)
      |-> ctrlWord == ($past(ctrlWord) | $past(strb.data)));

  assert_full_R4: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(strb.wrFull) |-> ctrlWord == $past(strb.data));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && !$past(strb.wrFull) && !$past(strb.setMask) && !$past(strb.clrMask)
      |-> $stable(ctrlWord));

  assert_strobe_src_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cntClearStb || cntSnapStb || trigFireStb) |-> $past(strb.cmd));

  assert_snap_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && !$past(cntSnapStb) |-> $stable(shadow[0]));
endmodule

// File: rtl/ctrl_alias_reg.sv
module ctrl_alias_reg
  import ctrl_alias_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NUM_SNAP = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic [ADDR_W-1:0]          wrAddr,
  input  logic [DATA_W-1:0]          wrData,
  input  logic [ADDR_W-1:0]          rdAddr,
  output logic [DATA_W-1:0]          rdData,
  input  logic [NUM_SNAP*DATA_W-1:0] liveCounts,
  output logic [DATA_W-1:0]          ctrlWord,
  output logic                       cntClearStb,
  output logic                       cntSnapStb,
  output logic                       trigFireStb
);
  regStrobe_t strb;

  ctrl_alias_decode #(.ADDR_W(ADDR_W)) uDecode (
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .strb(strb)
  );

  ctrl_alias_datapath #(.ADDR_W(ADDR_W), .NUM_SNAP(NUM_SNAP)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .liveCounts(liveCounts),
    .rdAddr(rdAddr), .rdData(rdData), .ctrlWord(ctrlWord),
    .cntClearStb(cntClearStb), .cntSnapStb(cntSnapStb), .trigFireStb(trigFireStb)
  );
endmodule

// File: tb/tb_ctrl_alias_reg.sv
module tb_ctrl_alias_reg;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [11:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [11:0] rdAddr = '0;
  logic [31:0] rdData;
  logic [127:0] liveCounts = '0;
  logic [31:0] ctrlWord;
  logic cntClearStb, cntSnapStb, trigFireStb;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference model state
  logic [31:0] mWord = '0;
  logic [31:0] mShadow [4] = '{default: '0};
  logic mClr = 0, mSnap = 0, mTrig = 0;

  always #10 clk = ~clk;

  ctrl_alias_reg dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .liveCounts(liveCounts),
    .ctrlWord(ctrlWord), .cntClearStb(cntClearStb), .cntSnapStb(cntSnapStb),
    .trigFireStb(trigFireStb)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] modelRead(input logic [11:0] a);
    if (a == 12'h03D || a == 12'h03E || a == 12'h03F) return mWord;
    if (a >= 12'h100 && a < 12'h104) return mShadow[a - 12'h100];
    return 32'h0;
  endfunction

  function automatic string readTag(input logic [11:0] a);
    if (a >= 12'h100 && a < 12'h104) return "R8 shadow read";
    if (a == 12'h02B || (a >= 12'h03D && a <= 12'h03F)) return "R7 alias/cmd read";
    return "R9 unmapped read";
  endfunction

  task automatic compareAll();
    check("R2/R3/R4/R5 ctrlWord", ctrlWord, mWord);
    check("R6 cntClearStb", {31'h0, cntClearStb}, {31'h0, mClr});
    check("R6 cntSnapStb", {31'h0, cntSnapStb}, {31'h0, mSnap});
    check("R6 trigFireStb", {31'h0, trigFireStb}, {31'h0, mTrig});
    check(readTag(rdAddr), rdData, modelRead(rdAddr));
  endtask

  // drive inputs at a negedge, let one posedge pass, advance model, compare
  task automatic step(input logic we, input logic [11:0] a, input logic [31:0] d,
                      input logic [11:0] ra);
    wrEn = we; wrAddr = a; wrData = d; rdAddr = ra;
    liveCounts = {$urandom, $urandom, $urandom, $urandom};
    @(negedge clk);
    if (mSnap) for (int i = 0; i < 4; i++) mShadow[i] = liveCounts[i*32 +: 32];
    mClr  = we && a == 12'h02B && d[0];
    mSnap = we && a == 12'h02B && d[1];
    mTrig = we && a == 12'h02B && d[2];
    if (we && a == 12'h03F) mWord = d;
    else if (we && a == 12'h03E) mWord = mWord | d;
    else if (we && a == 12'h03D) mWord = mWord & ~d;
    compareAll();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1: reset state
    check("R1 ctrlWord reset", ctrlWord, 32'h0);
    check("R1 strobes reset", {29'h0, cntClearStb, cntSnapStb, trigFireStb}, 32'h0);
    rdAddr = 12'h101; #1;
    check("R1 shadow reset", rdData, 32'h0);
    rstN = 1'b1;
    step(0, 12'h000, 32'h0, 12'h100);          // R1 after release
    // R4 full write, R2 clear, R3 set back to back
    step(1, 12'h03F, 32'hF0F0_1234, 12'h03F);  // R4
    step(1, 12'h03D, 32'h0000_0204, 12'h03D);  // R2
    step(1, 12'h03E, 32'h0F00_0001, 12'h03E);  // R3
    step(1, 12'h03E, 32'h8000_0000, 12'h03E);  // R3
    step(1, 12'h03D, 32'hFFFF_FFFF, 12'h03F);  // R2 clear all
    // R5: other addresses and command writes leave word alone
    step(1, 12'h03F, 32'hA5A5_5A5A, 12'h03F);
    step(1, 12'h020, 32'hFFFF_FFFF, 12'h020);  // R5, R9
    step(1, 12'h02B, 32'hFFFF_FFF8, 12'h02B);  // R6 high bits ignored, R7
    step(0, 12'h03F, 32'h0, 12'h03E);          // R5 wrEn low
    // R6 each strobe alone, then back to back
    step(1, 12'h02B, 32'h1, 12'h02B);
    step(1, 12'h02B, 32'h2, 12'h100);          // R8 snapshot
    step(1, 12'h02B, 32'h4, 12'h101);
    step(1, 12'h02B, 32'h7, 12'h102);
    step(1, 12'h02B, 32'h7, 12'h103);
    step(0, 12'h000, 32'h0, 12'h100);
    step(0, 12'h000, 32'h0, 12'h103);          // R8 hold
    step(0, 12'h000, 32'h0, 12'h104);          // R9
    step(0, 12'h000, 32'h0, 12'hFFF);          // R9
    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [11:0] addrs [7] = '{12'h03D, 12'h03E, 12'h03F, 12'h02B, 12'h101, 12'h055, 12'h100};
      logic [11:0] ras [9] = '{12'h03D, 12'h03E, 12'h03F, 12'h02B, 12'h100, 12'h101,
                               12'h102, 12'h103, 12'h3FF};
      step(1'($urandom), addrs[$urandom % 7], $urandom, ras[$urandom % 9]);
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule